// File: doc/BRIEF.md
# Serial Byte Transmitter with Line Break Override

This block turns bytes offered on a valid/ready input into asynchronous serial frames on a single output line. A frame begins with a low start bit, carries eight data bits least significant first, optionally adds a parity bit, and ends with one or two high stop bits. The parity bit can be computed as even or odd over the data, or fixed to a constant in stick mode. Each bit lasts exactly one interval of an externally supplied baud tick, which pulses for one clock once per bit time.

A protocol enable gates the whole transmitter. When it is low, no byte is accepted, the line rests high and any frame in flight is abandoned. A break input pulls the line low whatever the frame is doing. The break acts on the pin only: the frame sequencer keeps counting bits, so a frame that overlaps a break still ends on the baud tick where it would have ended anyway.

The frame options and the data byte are captured when a byte is accepted. Changes on those inputs while a frame is in flight affect only the next frame.

Top module: `uart_frame_tx`

## Requirements
- R1: While proto_en is 0, in_ready is 0, tx_out is 1 (even with brk_force set), and busy is 0 from the next clock on, abandoning any frame in flight.
- R2: While proto_en is 1 and brk_force is 1, tx_out is 0 in the same cycle.
- R3: After a byte is accepted, the line stays 1 until the first clock edge where baud_tick is 1; then it shows the start bit 0 followed by data bits 0 to 7; each bit advances only on a clock edge where baud_tick is 1.
- R4: A parity bit follows data bit 7 only when par_en is 1 at acceptance; otherwise the stop bits follow bit 7 directly.
- R5: With par_en 1 and par_stick 0, the parity bit equals the XOR of the eight data bits when par_even is 1, and its inverse when par_even is 0.
- R6: With par_en 1 and par_stick 1, the parity bit is 0 when par_even is 1 and 1 when par_even is 0, whatever the data.
- R7: The frame ends with one stop bit at level 1 when stop_two is 0 and two stop bits when stop_two is 1.
- R8: busy is 1 from the cycle after acceptance until the last stop bit ends, and 0 in idle.
- R9: in_ready is 1 exactly when proto_en is 1 and no frame is in flight; in_valid while in_ready is 0 is ignored.
- R10: brk_force does not alter sequencing: after a break is released the line shows the bit the frame has reached, and the frame ends on the same tick as without the break.
- R11: in_data, par_en, par_even, par_stick and stop_two are captured at acceptance; changes during a frame do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| proto_en | input | 1 | Transmitter enable |
| brk_force | input | 1 | Forces the line low while 1 |
| par_en | input | 1 | Insert a parity bit |
| par_even | input | 1 | Even parity select; in stick mode 1 gives parity 0 |
| par_stick | input | 1 | Fixed parity value mode |
| stop_two | input | 1 | Two stop bits when 1 |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Byte accepted when in_valid is also 1 |
| baud_tick | input | 1 | One-clock pulse per bit time |
| tx_out | output | 1 | Serial line |
| busy | output | 1 | Frame in flight |

## Verification
The bench goes after a break that starts and ends inside a frame: a design that stalled its sequencer during the break would end the frame late and show the wrong bit on release. It flips the frame options and data in the middle of a frame, which catches a design that reads them live instead of capturing them, and it drops the enable mid-frame while offering a byte, which a design that failed to abort or that still accepted would turn into a stray frame. Stick parity against data with every bit set and computed parity of both senses expose a swapped or inverted parity bit, and a baud tick on every clock with bytes held back to back exposes an off-by-one in the alignment or stop phases.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ALIGN,
    PH_START,
    PH_DATA,
    PH_PARITY,
    PH_STOP1,
    PH_STOP2
  } tx_phase_e;

  typedef struct packed {
    logic par_en;
    logic par_even;
    logic par_stick;
    logic stop_two;
  } frame_cfg_t;

endpackage

// File: rtl/uart_tx_rst_sync.sv
module uart_tx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  frame_cfg_t        cfg,
  output logic              par_bit
);

  logic ones_odd;

  assign ones_odd = ^data;

  always_comb begin
    if (cfg.par_stick) begin
      par_bit = ~cfg.par_even;
    end else if (cfg.par_even) begin
      par_bit = ones_odd;
    end else begin
      par_bit = ~ones_odd;
    end
  end

endmodule

// File: rtl/uart_tx_sequencer.sv
module uart_tx_sequencer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proto_en,
  input  logic              baud_tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  frame_cfg_t        cfg_in,
  input  logic              par_in,
  output logic              in_ready,
  output logic              busy,
  output logic              line_bit
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  tx_phase_e         phase_q, phase_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              par_q, par_d;
  logic              pen_q, pen_d;
  logic              two_q, two_d;
  logic              load_en;
  logic              take;

  assign in_ready = proto_en && (phase_q == PH_IDLE) && rst_n;
  assign take     = in_valid && in_ready;
  assign busy     = (phase_q != PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    par_d   = par_q;
    pen_d   = pen_q;
    two_d   = two_q;
    load_en = 1'b0;
    if (!proto_en) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (take) begin
            phase_d = PH_ALIGN;
            shreg_d = in_data;
            par_d   = par_in;
            pen_d   = cfg_in.par_en;
            two_d   = cfg_in.stop_two;
            load_en = 1'b1;
          end
        end
        PH_ALIGN: if (baud_tick) phase_d = PH_START;
        PH_START: begin
          if (baud_tick) begin
            phase_d = PH_DATA;
            cnt_d   = '0;
            load_en = 1'b1;
          end
        end
        PH_DATA: begin
          if (baud_tick) begin
            shreg_d = shreg_q >> 1;
            cnt_d   = cnt_q + 1'b1;
            load_en = 1'b1;
            if (cnt_q == LAST_IDX) begin
              phase_d = pen_q ? PH_PARITY : PH_STOP1;
            end
          end
        end
        PH_PARITY: if (baud_tick) phase_d = PH_STOP1;
        PH_STOP1:  if (baud_tick) phase_d = two_q ? PH_STOP2 : PH_IDLE;
        PH_STOP2:  if (baud_tick) phase_d = PH_IDLE;
        default:   phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      par_q   <= 1'b0;
      pen_q   <= 1'b0;
      two_q   <= 1'b0;
    end else if (load_en) begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      par_q   <= par_d;
      pen_q   <= pen_d;
      two_q   <= two_d;
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_START:  line_bit = 1'b0;
      PH_DATA:   line_bit = shreg_q[0];
      PH_PARITY: line_bit = par_q;
      default:   line_bit = 1'b1;
    endcase
  end

endmodule

// File: rtl/uart_tx_line_drive.sv
module uart_tx_line_drive (
  input  logic proto_en,
  input  logic brk_force,
  input  logic line_bit,
  output logic tx_out
);

  always_comb begin
    if (!proto_en) begin
      tx_out = 1'b1;
    end else if (brk_force) begin
      tx_out = 1'b0;
    end else begin
      tx_out = line_bit;
    end
  end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proto_en,
  input  logic              brk_force,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic              stop_two,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              baud_tick,
  output logic              tx_out,
  output logic              busy
);

  logic       rst_n_int;
  logic       par_bit;
  logic       line_bit;
  frame_cfg_t cfg;

  assign cfg = '{par_en: par_en, par_even: par_even,
                 par_stick: par_stick, stop_two: stop_two};

  uart_tx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  uart_tx_parity #(.DATA_W(DATA_W)) u_par (
    .data    (in_data),
    .cfg     (cfg),
    .par_bit (par_bit)
  );

  uart_tx_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .proto_en  (proto_en),
    .baud_tick (baud_tick),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .cfg_in    (cfg),
    .par_in    (par_bit),
    .in_ready  (in_ready),
    .busy      (busy),
    .line_bit  (line_bit)
  );

  uart_tx_line_drive u_drv (
    .proto_en  (proto_en),
    .brk_force (brk_force),
    .line_bit  (line_bit),
    .tx_out    (tx_out)
  );

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic proto_en,
  input logic brk_force,
  input logic in_valid,
  input logic in_ready,
  input logic baud_tick,
  input logic tx_out,
  input logic busy
);

  a_r1_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !proto_en |-> (tx_out && !in_ready));

  a_r1_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !proto_en |=> !busy);

  a_r2_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_en && brk_force) |-> !tx_out);

  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!busy && proto_en));

  a_r8_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_en && busy && !baud_tick) |=>
      ((tx_out == $past(tx_out)) || (brk_force != $past(brk_force)) || !proto_en));

endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .proto_en  (proto_en),
  .brk_force (brk_force),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .baud_tick (baud_tick),
  .tx_out    (tx_out),
  .busy      (busy)
);

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       proto_en, brk_force, par_en, par_even, par_stick, stop_two;
  logic       in_valid, baud_tick;
  logic [7:0] in_data;
  logic       in_ready, tx_out, busy;

  uart_frame_tx #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .proto_en(proto_en), .brk_force(brk_force),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .stop_two(stop_two), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .baud_tick(baud_tick), .tx_out(tx_out), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // stimulus variables
  logic pe, brk, pen, pev, pst, two, vld;
  logic [7:0] dat;
  int div, tcnt;
  bit acc;
  bit done = 0;
  string scen;
  int checks = 0, fails = 0;

  // reference model: remaining line levels and bit kinds
  // kinds: 0 align, 1 start, 2 data, 3 parity, 4 stop
  logic qv[$];
  int   qk[$];

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%b expected=%b at %0t", req, scen, act, exp, $time);
    end
  endtask

  task automatic build(input logic [7:0] d);
    logic p;
    qv.push_back(1'b1); qk.push_back(0);
    qv.push_back(1'b0); qk.push_back(1);
    for (int i = 0; i < 8; i++) begin
      qv.push_back(d[i]); qk.push_back(2);
    end
    if (pen) begin
      if (pst) p = ~pev;
      else p = pev ? ^d : ~(^d);
      qv.push_back(p); qk.push_back(3);
    end
    qv.push_back(1'b1); qk.push_back(4);
    if (two) begin
      qv.push_back(1'b1); qk.push_back(4);
    end
  endtask

  task automatic step();
    logic tick, exp_tx;
    string tag;
    @(negedge clk);
    tick = (tcnt == div - 1);
    tcnt = (tcnt + 1) % div;
    proto_en = pe; brk_force = brk; par_en = pen; par_even = pev;
    par_stick = pst; stop_two = two; in_valid = vld; in_data = dat;
    baud_tick = tick;
    #1;
    if (!pe) begin
      exp_tx = 1'b1; tag = "R1";
    end else if (brk) begin
      exp_tx = 1'b0; tag = "R2";
    end else if (qv.size() == 0) begin
      exp_tx = 1'b1; tag = "R3";
    end else begin
      exp_tx = qv[0];
      case (qk[0])
        3: tag = pst ? "R6" : "R5";
        4: tag = "R7";
        default: tag = "R3";
      endcase
    end
    check(tag, tx_out, exp_tx);
    check("R8", busy, qv.size() != 0);
    check("R9", in_ready, pe && (qv.size() == 0));
    acc = 0;
    if (!pe) begin
      qv.delete(); qk.delete();
    end else if (qv.size() != 0) begin
      if (tick) begin
        void'(qv.pop_front()); void'(qk.pop_front());
      end
    end else if (vld) begin
      build(dat);
      acc = 1;
    end
  endtask

  task automatic send(input logic [7:0] d);
    dat = d; vld = 1'b1;
    for (int n = 0; n < 400; n++) begin
      step();
      if (acc) break;
    end
    vld = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 400; n++) begin
      if (qv.size() == 0) break;
      step();
    end
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    pe = 1; brk = 0; pen = 0; pev = 0; pst = 0; two = 0; vld = 0; dat = 8'h00;
    div = 4; tcnt = 0; scen = "reset";
    proto_en = 1; brk_force = 0; par_en = 0; par_even = 0; par_stick = 0;
    stop_two = 0; in_valid = 0; in_data = 0; baud_tick = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    // reset state (R8, R9): line high, not busy, not ready while in reset
    check("R8", busy, 1'b0);
    check("R3", tx_out, 1'b1);
    check("R9", in_ready, 1'b0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R3 R4 R7: no parity, one stop bit
    scen = "8N1"; send(8'hA5); wait_idle();
    // R5 even parity
    scen = "even"; pen = 1; pev = 1; send(8'h3C); wait_idle();
    send(8'h07); wait_idle();
    // R5 odd parity with R7 two stop bits
    scen = "odd two-stop"; pev = 0; two = 1; send(8'h07); wait_idle();
    send(8'hFF); wait_idle();
    // R6 stick parity both senses
    scen = "stick"; two = 0; pst = 1; pev = 1; send(8'hFF); wait_idle();
    pev = 0; send(8'h00); wait_idle();
    pst = 0;

    // R2 R10: break in the middle of a frame
    scen = "break mid-frame"; pen = 1; pev = 1; send(8'h96);
    repeat (10) step();
    brk = 1; repeat (13) step();
    brk = 0; wait_idle();

    // R9: valid held while busy is not taken until idle
    scen = "valid while busy"; pen = 0; send(8'h11);
    dat = 8'h22; vld = 1;
    for (int n = 0; n < 400; n++) begin
      step();
      if (acc) break;
    end
    vld = 0; wait_idle();

    // R11: options and data changed mid-frame
    scen = "mid-frame change"; pen = 1; pev = 1; two = 0; send(8'h5A);
    repeat (8) step();
    pen = 0; two = 1; pev = 0; pst = 1; dat = 8'h00;
    wait_idle();
    pen = 0; two = 0; pst = 0;

    // R1: enable dropped mid-frame while a byte is offered
    scen = "disable mid-frame"; send(8'hC3);
    repeat (10) step();
    pe = 0; brk = 1; dat = 8'h99; vld = 1; repeat (6) step();
    brk = 0; vld = 0; pe = 1; repeat (3) step();

    // R3 R8: tick every clock, bytes back to back
    scen = "back-to-back"; div = 1; tcnt = 0; pen = 1; pev = 0; two = 1;
    for (int k = 0; k < 4; k++) send(8'h31 + 8'(k * 37));
    wait_idle();
    div = 3; tcnt = 0; two = 0;
    send(8'h80); wait_idle();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule